// File: doc/BRIEF.md
# Pin and Edge Interrupt Front End

This block is the interrupt front end of a small processor core. It watches one dedicated external interrupt line and sixteen general-purpose pins. The general pins form two groups of eight. Pins 0 to 7 are group 0 and pins 8 to 15 are group 1. Each pin has its own enable bit, but every group shares one flag. The external line has its own flag. Its trigger can be any change, a falling edge or a rising edge. It can also be set to low-level sensing, which bypasses the flag.

All inputs first pass through a two-flop synchronizer. A change is detected by comparing the synchronized value with its value one clock earlier. Software reaches the block through a small register port: one control register, one flag register and two mask registers.

The block drives one request line toward the CPU, along with a vector code for the most urgent pending source. The CPU acknowledges by naming the source it is servicing, and that source's flag then clears.

Top module: `pinirq_ctrl`

Register map used below:
- Address 0 is the control register.
  - Bit 0 enables the external source.
  - Bit 1 enables group 0.
  - Bit 2 enables group 1.
  - Bits 7:6 select the external sense mode: 00 low level, 01 any change, 10 falling edge, 11 rising edge.
- Address 1 is the flag register.
  - Bit 0 is the external flag.
  - Bit 1 is the group 0 flag.
  - Bit 2 is the group 1 flag.
  - Writing a one clears the bit.
- Address 2 is the mask register for group 0, one bit per pin 0 to 7.
- Address 3 is the mask register for group 1, one bit per pin 8 to 15.

## Requirements
- R1: After reset, all four registers read zero and `irq_req` is low.
- R2: Both mask registers (addresses 2 and 3) can be written, and they read back the value written.
- R3: A pin change while the pin's mask bit is one sets its group's flag on the third rising clock edge after the change. A change on a pin whose mask bit is zero leaves the flags unchanged.
- R4: A flag source requests only when its flag, its enable bit in the control register and `gie` are all one.
- R5: Writing a one to a flag bit clears that flag. Writing a zero to a flag bit leaves it unchanged.
- R6: An acknowledge with `ack_vec` equal to 0 (external), 1 (group 0) or 2 (group 1) clears only that source's flag.
- R7: If a hardware set and a clear of the same flag happen in the same cycle, the flag ends up set.
- R8: In sense mode 01 any change of the external line sets the external flag. In mode 10 only a falling edge sets it, and in mode 11 only a rising edge.
- R9: In sense mode 00 the external flag is held at zero. In that mode the external request is high while the synchronized line is low, the external enable bit is one and `gie` is one.
- R10: When several sources request at once, `irq_vec` gives the highest-priority one: external is code 0, group 0 is code 1 and group 1 is code 2, in that order of priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Dedicated external interrupt line |
| io_pins | input | 16 | General pins, group 0 in bits 7:0 and group 1 in bits 15:8 |
| gie | input | 1 | Global interrupt enable from the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ack | input | 1 | Vector acknowledge from the core |
| ack_vec | input | 2 | Source code being acknowledged |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 2 | Code of the highest-priority pending source |

## Verification
A flag can be set by a detected pin change and cleared in the same cycle, either by a write of one or by an acknowledge. The bench provokes this case directly. It toggles a masked pin that was already flagged and times a write of one to that flag so that the write lands on the third clock edge after the toggle. That edge is the one on which the synchronized change sets the flag. The flag is then read back and must still be one. A clear-wins design would read zero.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
    localparam int NUM_GROUPS = 2;
    localparam int GROUP_W    = 8;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int NSRC       = NUM_GROUPS + 1;
    localparam int VEC_W      = $clog2(NSRC + 1);
    localparam int PIN_W      = NUM_GROUPS * GROUP_W;
    localparam int SENSE_LSB  = 6;
    localparam int MASK_BASE  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(1);

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    function automatic logic ext_event(sense_e m, logic cur, logic prv);
        case (m)
            SENSE_ANY:  return cur ^ prv;
            SENSE_FALL: return prv & ~cur;
            SENSE_RISE: return cur & ~prv;
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prv    <= '0;
        end else begin
            meta_q <= din;
            cur    <= meta_q;
            prv    <= cur;
        end
    end
endmodule

// File: rtl/pinirq_group.sv
module pinirq_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] chg,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic         flag_clr,
    output logic [W-1:0] mask,
    output logic         flag,
    output logic         set
);
    assign set = |(chg & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            flag <= 1'b0;
        end else begin
            if (mask_we) mask <= mask_wdata;
            flag <= set | (flag & ~flag_clr);
        end
    end
endmodule

// File: rtl/pinirq_ext.sv
module pinirq_ext
    import pinirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cur,
    input  logic   prv,
    input  sense_e sense,
    input  logic   flag_clr,
    output logic   flag,
    output logic   set
);
    assign set = ext_event(sense, cur, prv);

    always_ff @(posedge clk) begin
        if (rst || sense == SENSE_LOW) flag <= 1'b0;
        else                           flag <= set | (flag & ~flag_clr);
    end
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
    import pinirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic [PIN_W-1:0]  io_pins,
    input  logic              gie,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ack,
    input  logic [VEC_W-1:0]  ack_vec,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    logic [PIN_W:0]       sync_cur, sync_prv;
    logic [PIN_W-1:0]     pin_chg;
    logic [NSRC-1:0]      en_q, flag_v, set_v, clr_v, pend_v;
    sense_e               sense_q;
    logic [GROUP_W-1:0]   mask_q [NUM_GROUPS];

    pinirq_sync #(.W(PIN_W + 1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({io_pins, ext_pin}),
        .cur (sync_cur),
        .prv (sync_prv)
    );

    assign pin_chg = sync_cur[PIN_W:1] ^ sync_prv[PIN_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            sense_q <= SENSE_LOW;
        end else if (reg_we && reg_addr == A_CTRL) begin
            en_q    <= reg_wdata[NSRC-1:0];
            sense_q <= sense_e'(reg_wdata[SENSE_LSB +: 2]);
        end
    end

    always_comb begin
        clr_v = '0;
        if (reg_we && reg_addr == A_FLAGS) clr_v = reg_wdata[NSRC-1:0];
        for (int i = 0; i < NSRC; i++)
            if (ack && ack_vec == VEC_W'(i)) clr_v[i] = 1'b1;
    end

    pinirq_ext u_ext (
        .clk      (clk),
        .rst      (rst),
        .cur      (sync_cur[0]),
        .prv      (sync_prv[0]),
        .sense    (sense_q),
        .flag_clr (clr_v[0]),
        .flag     (flag_v[0]),
        .set      (set_v[0])
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        pinirq_group #(.W(GROUP_W)) u_grp (
            .clk        (clk),
            .rst        (rst),
            .chg        (pin_chg[g*GROUP_W +: GROUP_W]),
            .mask_we    (reg_we && reg_addr == ADDR_W'(MASK_BASE + g)),
            .mask_wdata (reg_wdata[GROUP_W-1:0]),
            .flag_clr   (clr_v[g+1]),
            .mask       (mask_q[g]),
            .flag       (flag_v[g+1]),
            .set        (set_v[g+1])
        );
    end

    always_comb begin
        pend_v[0] = ((sense_q == SENSE_LOW) ? ~sync_cur[0] : flag_v[0]) & en_q[0] & gie;
        for (int i = 1; i < NSRC; i++) pend_v[i] = flag_v[i] & en_q[i] & gie;
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        irq_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (!found && pend_v[i]) begin
                irq_vec = VEC_W'(i);
                found   = 1'b1;
            end
        end
    end

    assign irq_req = |pend_v;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[NSRC-1:0]       = en_q;
            reg_rdata[SENSE_LSB +: 2] = sense_q;
        end else if (reg_addr == A_FLAGS) begin
            reg_rdata[NSRC-1:0] = flag_v;
        end
        for (int g = 0; g < NUM_GROUPS; g++)
            if (reg_addr == ADDR_W'(MASK_BASE + g)) reg_rdata[GROUP_W-1:0] = mask_q[g];
    end
endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker
    import pinirq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             gie,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input sense_e           sense_q,
    input logic [NSRC-1:0]  en_q,
    input logic [NSRC-1:0]  flag_v,
    input logic [NSRC-1:0]  set_v,
    input logic [NSRC-1:0]  clr_v
);
    a_r4_req_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> gie);

    a_r9_level_flag_zero: assert property (@(posedge clk) disable iff (rst)
        (sense_q == SENSE_LOW) |=> !flag_v[0]);

    a_r7_set_wins_g0: assert property (@(posedge clk) disable iff (rst)
        set_v[1] |=> flag_v[1]);

    a_r7_set_wins_g1: assert property (@(posedge clk) disable iff (rst)
        set_v[2] |=> flag_v[2]);

    a_r5_clear_g0: assert property (@(posedge clk) disable iff (rst)
        (clr_v[1] && !set_v[1]) |=> !flag_v[1]);

    a_r10_priority: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_vec == VEC_W'(2)) |-> !(flag_v[1] && en_q[1] && gie));
endmodule

bind pinirq_ctrl pinirq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .gie     (gie),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .sense_q (sense_q),
    .en_q    (en_q),
    .flag_v  (flag_v),
    .set_v   (set_v),
    .clr_v   (clr_v)
);

// File: tb/pinirq_ctrl_test.sv
module pinirq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_pin = 1'b0;
    logic [15:0] io_pins = '0;
    logic        gie = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ack = 1'b0;
    logic [1:0]  ack_vec = '0;
    logic        irq_req;
    logic [1:0]  irq_vec;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pinirq_ctrl uut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .io_pins(io_pins), .gie(gie),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack(ack), .ack_vec(ack_vec), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_io(input logic [15:0] v);
        @(negedge clk);
        io_pins = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ext(input logic v);
        @(negedge clk);
        ext_pin = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic give_ack(input logic [1:0] v);
        @(negedge clk);
        ack = 1'b1; ack_vec = v;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg after reset", v, 0);
        end
        chk("R1 irq_req after reset", irq_req, 0);
    endtask

    task automatic t_masks;
        logic [7:0] v;
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h3C);
        rd(2'd2, v); chk("R2 mask0 readback", v, 8'hA5);
        rd(2'd3, v); chk("R2 mask1 readback", v, 8'h3C);
    endtask

    task automatic t_group;
        logic [7:0] v;
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h80);
        set_io(16'h0002);
        rd(2'd1, v); chk("R3 unmasked pin ignored", v, 0);
        set_io(16'h0003);
        rd(2'd1, v); chk("R3 masked pin sets group0", v, 8'h02);
        set_io(16'h8003);
        rd(2'd1, v); chk("R3 masked pin sets group1", v, 8'h06);
    endtask

    task automatic t_enable;
        wr(2'd0, 8'h00);
        #1 chk("R4 no enables no request", irq_req, 0);
        gie = 1'b1;
        #1 chk("R4 gie alone no request", irq_req, 0);
        wr(2'd0, 8'h04);
        #1 chk("R4 group1 request", irq_req, 1);
        chk("R10 group1 vector", irq_vec, 2);
        gie = 1'b0;
        #1 chk("R4 gie low blocks", irq_req, 0);
        gie = 1'b1;
        wr(2'd0, 8'h06);
        #1 chk("R10 group0 above group1", irq_vec, 1);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R5 write zero no effect", v, 8'h06);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R5 write one clears", v, 8'h04);
        give_ack(2'd1);
        rd(2'd1, v); chk("R6 ack of other source keeps flag", v, 8'h04);
        give_ack(2'd2);
        rd(2'd1, v); chk("R6 ack clears group1", v, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        set_io(16'h8002);
        rd(2'd1, v); chk("R7 precondition group0 set", v, 8'h02);
        @(negedge clk);
        io_pins = 16'h8003;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h02;
        @(negedge clk);
        reg_we = 1'b0;
        rd(2'd1, v); chk("R7 set beats write clear", v, 8'h02);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R7 cleared afterwards", v, 8'h00);
    endtask

    task automatic t_ext;
        logic [7:0] v;
        wr(2'd0, 8'h40);
        set_ext(1'b1);
        rd(2'd1, v); chk("R8 any change rise", v, 8'h01);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h80);
        set_ext(1'b0);
        rd(2'd1, v); chk("R8 falling mode on fall", v, 8'h01);
        wr(2'd1, 8'h01);
        set_ext(1'b1);
        rd(2'd1, v); chk("R8 falling mode ignores rise", v, 8'h00);
        wr(2'd0, 8'hC0);
        set_ext(1'b0);
        rd(2'd1, v); chk("R8 rising mode ignores fall", v, 8'h00);
        set_ext(1'b1);
        rd(2'd1, v); chk("R8 rising mode on rise", v, 8'h01);
    endtask

    task automatic t_level;
        logic [7:0] v;
        wr(2'd0, 8'h01);
        rd(2'd1, v); chk("R9 level mode forces flag zero", v, 8'h00);
        #1 chk("R9 high line no request", irq_req, 0);
        set_ext(1'b0);
        chk("R9 low line requests", irq_req, 1);
        chk("R10 external vector", irq_vec, 0);
        wr(2'd0, 8'h07);
        set_io(16'h8002);
        #1 chk("R10 external above group0", irq_vec, 0);
        set_ext(1'b1);
        chk("R10 group0 after external drops", irq_vec, 1);
        rd(2'd1, v); chk("R9 flag stays zero after level", v, 8'h02);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masks();
        t_group();
        t_enable();
        t_clear();
        t_collide();
        t_ext();
        t_level();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule